// File: doc/BRIEF.md
# Linked Descriptor DMA Channel

One DMA channel that reads an eight-word descriptor from memory and carries it out as a series of transfer units moved from a source address to a target address. Each unit is split into beats no wider than the memory port. Every beat is one read followed by one write, with the bytes shifted between lanes so that sub-word units land at the right byte offsets. When the last unit of a descriptor is done, the channel does one of two things. If the descriptor has its link flag set, the channel fetches the next descriptor, whose address is the base address plus an 8-bit offset times 16. If the link flag is clear, the channel stops and records termination.

Software writes the base descriptor address and rings the doorbell input. Once the channel enable bit is set, the fetched descriptor starts to run. A descriptor runs freely when its request word selects automatic requests. Otherwise each unit waits for the peripheral request input. A link offset of zero points back at the base descriptor, so a chain can be closed into a ring that runs until software stops it.

Top module: `dlc_dma_channel`

## Requirements
- R1: After reset the descriptor address, control/status and live count registers all read 0, the interrupt is low and no memory access is made.
- R2: The descriptor layout in memory is: word 0 command, word 1 source address, word 2 target address, word 3 count (bits 23:0) with link offset (bits 31:24), word 5 request type. Words 4, 6 and 7 are read but not used. A fetch of eight words from the base address starts only on a doorbell pulse that comes after a write to the descriptor address register (register address 0), and each such write allows one fetch. A doorbell pulse with no such prior write has no effect.
- R3: A fetched descriptor moves no data until control/status bit 0 (enable, register address 1) is 1. While it waits, the live count register (register address 2) shows the count just loaded.
- R4: Command bits 10:8 select the unit size: 0=4, 1=1, 2=2, 3=16, 4=32, 5=64, 6=128 bytes. A descriptor moves count times unit bytes. Beats are min(unit,4) bytes wide, and the byte lanes of source and target follow the low address bits.
- R5: Command bit 23 set makes the source address advance by one beat width after each beat, and bit 22 does the same for the target address. A clear bit holds that address fixed.
- R6: A request type word equal to 8 lets units run back to back. With any other value, each unit starts only while the peripheral request input is high. The live count drops by one as each unit completes.
- R7: With command bit 0 (link) set, the descriptor that follows is fetched from the base address plus the link offset times 16, and it runs without further software action.
- R8: A linked descriptor whose link offset is 0 leads back to the base descriptor, so the chain runs as a ring.
- R9: When a descriptor with the link flag clear completes, control/status bit 3 (terminated) is set. The interrupt output is high while bit 3 is set and that descriptor's command bit 1 was set, and it stays high until software clears bit 3.
- R10: Completing a linked descriptor raises neither bit 3 nor the interrupt.
- R11: When the unit code is 7, or the source or target address is not a multiple of the unit size, control/status bit 4 (address error) is set and the channel stops without writing memory.
- R12: A write to control/status loads bit 0 (enable) and bit 30 (8-word format). Each status bit (2, 3, 4) is kept where the written bit is 1 and cleared where it is 0, so writing 0 clears all status. Writing a value that is nonzero but has bit 0 clear while the channel is busy stops it and sets bit 2 (halt).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 descriptor address, 1 control/status, 2 live count |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| doorbell | input | 1 | Fetch request pulse |
| per_req | input | 1 | Peripheral request level |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_rdata | input | 32 | Read data for the current read request |
| mem_ready | input | 1 | Memory completes the access this cycle |
| irq | output | 1 | Transfer-end interrupt |

## Verification
A fault in the lane-shift or address-step logic shows up as wrong target bytes once the descriptor's final beat is written. A unit counter that skips or stalls shows in the live count register on the very next cycle, and it also makes the final write either come early or never arrive. A wrong link-address calculation makes the channel fetch a stale or unrelated descriptor, so the ring and chain tests end with the wrong memory image or with no interrupt at all. A broken status update shows up in the control/status word or on the interrupt pin the cycle after the descriptor ends.

// File: rtl/dlc_dma_pkg.sv
package dlc_dma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_WAIT,
      ST_CHECK,
      ST_REQ,
      ST_RD,
      ST_WR,
      ST_NEXT
   } dlc_state_e;

   // register select values
   localparam logic [1:0] RA_DESC  = 2'd0;
   localparam logic [1:0] RA_CTRL  = 2'd1;
   localparam logic [1:0] RA_COUNT = 2'd2;

   // control/status bit positions
   localparam int CB_EN       = 0;
   localparam int CB_HALT     = 2;
   localparam int CB_TERM     = 3;
   localparam int CB_ADDR_ERR = 4;
   localparam int CB_D8       = 30;

   // command word bit positions
   localparam int MB_LINK     = 0;
   localparam int MB_IE       = 1;
   localparam int MB_UNIT_LO  = 8;
   localparam int MB_TGT_INC  = 22;
   localparam int MB_SRC_INC  = 23;

   // descriptor word indices
   localparam int DW_CMD   = 0;
   localparam int DW_SRC   = 1;
   localparam int DW_TGT   = 2;
   localparam int DW_COUNT = 3;
   localparam int DW_RTYPE = 5;

endpackage

// File: rtl/dlc_unit_decode.sv
module dlc_unit_decode #(
   parameter int LANES = 4
) (
   input  logic [2:0] code,
   output logic       code_ok,
   output logic [7:0] unit_bytes,
   output logic [7:0] beat_bytes,
   output logic [7:0] beats_m1
);
   localparam int LSH = $clog2(LANES);

   always_comb begin
      code_ok = 1'b1;
      case (code)
         3'd0:    unit_bytes = 8'd4;
         3'd1:    unit_bytes = 8'd1;
         3'd2:    unit_bytes = 8'd2;
         3'd3:    unit_bytes = 8'd16;
         3'd4:    unit_bytes = 8'd32;
         3'd5:    unit_bytes = 8'd64;
         3'd6:    unit_bytes = 8'd128;
         default: begin
            unit_bytes = 8'd4;
            code_ok    = 1'b0;
         end
      endcase
   end

   always_comb begin
      if (unit_bytes < 8'(LANES)) begin
         beat_bytes = unit_bytes;
         beats_m1   = 8'd0;
      end else begin
         beat_bytes = 8'(LANES);
         beats_m1   = (unit_bytes >> LSH) - 8'd1;
      end
   end

endmodule

// File: rtl/dlc_lane_shift.sv
module dlc_lane_shift #(
   parameter  int LANES = 4,
   localparam int LSH   = $clog2(LANES),
   localparam int DW    = 8 * LANES
) (
   input  logic [DW-1:0]    rdata,
   input  logic [LSH-1:0]   src_ofs,
   input  logic [LSH-1:0]   tgt_ofs,
   input  logic [7:0]       beat_bytes,
   output logic [DW-1:0]    wdata,
   output logic [LANES-1:0] be
);
   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic           in_beat;
      logic [LSH-1:0] from_lane;
      assign in_beat   = (j >= int'(tgt_ofs)) &&
                         (j < int'(tgt_ofs) + int'(beat_bytes));
      assign from_lane = LSH'(j - int'(tgt_ofs) + int'(src_ofs));
      assign be[j]           = in_beat;
      assign wdata[8*j +: 8] = rdata[8*from_lane +: 8];
   end

endmodule

// File: rtl/dlc_dma_channel.sv
module dlc_dma_channel
   import dlc_dma_pkg::*;
#(
   parameter int          AW         = 32,
   parameter int          LANES      = 4,
   parameter int          CNT_W      = 24,
   parameter int          OFS_W      = 8,
   parameter int          OFS_SHIFT  = 4,
   parameter int          DESC_WORDS = 8,
   parameter logic [31:0] AUTO_RTYPE = 32'd8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               reg_we,
   input  logic [1:0]         reg_addr,
   input  logic [8*LANES-1:0] reg_wdata,
   output logic [8*LANES-1:0] reg_rdata,
   input  logic               doorbell,
   input  logic               per_req,
   output logic               mem_req,
   output logic               mem_we,
   output logic [AW-1:0]      mem_addr,
   output logic [8*LANES-1:0] mem_wdata,
   output logic [LANES-1:0]   mem_be,
   input  logic [8*LANES-1:0] mem_rdata,
   input  logic               mem_ready,
   output logic               irq
);
   localparam int DW     = 8 * LANES;
   localparam int LSH    = $clog2(LANES);
   localparam int WIDX_W = $clog2(DESC_WORDS);

   if (DW != 32 || AW != 32)
      $error("dlc_dma_channel: 32-bit data and address paths are required");
   if (CNT_W + OFS_W != DW)
      $error("dlc_dma_channel: count and offset fields must fill one word");
   if (DESC_WORDS < DW_RTYPE + 1 || (1 << WIDX_W) != DESC_WORDS)
      $error("dlc_dma_channel: descriptor length must be a power of two holding all fields");

   dlc_state_e        state_q;
   logic [AW-1:0]     base_q, cur_q, src_q, tgt_q;
   logic              dar_set_q, en_q, d8_q, halt_q, tt_q, ar_q, ie_q;
   logic              link_q, cmd_ie_q, sai_q, dai_q, auto_q;
   logic [2:0]        unit_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [OFS_W-1:0]  ofs_q;
   logic [WIDX_W-1:0] widx_q;
   logic [7:0]        beat_q;
   logic [DW-1:0]     data_q;

   logic              code_ok;
   logic [7:0]        unit_bytes, beat_bytes, beats_m1;
   logic [DW-1:0]     shifted;
   logic [LANES-1:0]  lane_be;
   logic              busy, ctrl_wr, misaligned, cnt_load;
   logic [AW-1:0]     unit_mask, link_addr, word_mask;

   dlc_unit_decode #(.LANES(LANES)) u_dec (
      .code       (unit_q),
      .code_ok    (code_ok),
      .unit_bytes (unit_bytes),
      .beat_bytes (beat_bytes),
      .beats_m1   (beats_m1)
   );

   dlc_lane_shift #(.LANES(LANES)) u_shift (
      .rdata      (data_q),
      .src_ofs    (src_q[LSH-1:0]),
      .tgt_ofs    (tgt_q[LSH-1:0]),
      .beat_bytes (beat_bytes),
      .wdata      (shifted),
      .be         (lane_be)
   );

   assign busy       = (state_q != ST_IDLE);
   assign ctrl_wr    = reg_we && (reg_addr == RA_CTRL);
   assign unit_mask  = AW'(unit_bytes) - AW'(1);
   assign misaligned = |((src_q | tgt_q) & unit_mask);
   assign link_addr  = base_q + (AW'(ofs_q) << OFS_SHIFT);
   assign word_mask  = ~AW'(LANES - 1);
   assign cnt_load   = (state_q == ST_FETCH) && mem_ready &&
                       (widx_q == WIDX_W'(DW_COUNT));

   // memory master
   always_comb begin
      mem_req   = (state_q == ST_FETCH) || (state_q == ST_RD) || (state_q == ST_WR);
      mem_we    = (state_q == ST_WR);
      mem_wdata = shifted;
      mem_be    = (state_q == ST_WR) ? lane_be : '0;
      case (state_q)
         ST_FETCH: mem_addr = cur_q + (AW'(widx_q) << LSH);
         ST_RD:    mem_addr = src_q & word_mask;
         ST_WR:    mem_addr = tgt_q & word_mask;
         default:  mem_addr = '0;
      endcase
   end

   // register read
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_DESC:  reg_rdata = DW'(base_q);
         RA_CTRL: begin
            reg_rdata[CB_EN]       = en_q;
            reg_rdata[CB_HALT]     = halt_q;
            reg_rdata[CB_TERM]     = tt_q;
            reg_rdata[CB_ADDR_ERR] = ar_q;
            reg_rdata[CB_D8]       = d8_q;
         end
         RA_COUNT: reg_rdata = DW'(cnt_q);
         default:  reg_rdata = '0;
      endcase
   end

   assign irq = tt_q && ie_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         base_q    <= '0;
         cur_q     <= '0;
         src_q     <= '0;
         tgt_q     <= '0;
         dar_set_q <= 1'b0;
         en_q      <= 1'b0;
         d8_q      <= 1'b0;
         halt_q    <= 1'b0;
         tt_q      <= 1'b0;
         ar_q      <= 1'b0;
         ie_q      <= 1'b0;
         link_q    <= 1'b0;
         cmd_ie_q  <= 1'b0;
         sai_q     <= 1'b0;
         dai_q     <= 1'b0;
         auto_q    <= 1'b0;
         unit_q    <= '0;
         cnt_q     <= '0;
         ofs_q     <= '0;
         widx_q    <= '0;
         beat_q    <= '0;
         data_q    <= '0;
      end else begin
         if (reg_we && reg_addr == RA_DESC) begin
            base_q    <= AW'(reg_wdata);
            dar_set_q <= 1'b1;
         end
         case (state_q)
            ST_IDLE: if (doorbell && dar_set_q) begin
               state_q   <= ST_FETCH;
               cur_q     <= base_q;
               widx_q    <= '0;
               dar_set_q <= 1'b0;
            end
            ST_FETCH: if (mem_ready) begin
               if (widx_q == WIDX_W'(DW_CMD)) begin
                  link_q   <= mem_rdata[MB_LINK];
                  cmd_ie_q <= mem_rdata[MB_IE];
                  unit_q   <= mem_rdata[MB_UNIT_LO +: 3];
                  sai_q    <= mem_rdata[MB_SRC_INC];
                  dai_q    <= mem_rdata[MB_TGT_INC];
               end
               if (widx_q == WIDX_W'(DW_SRC))   src_q <= AW'(mem_rdata);
               if (widx_q == WIDX_W'(DW_TGT))   tgt_q <= AW'(mem_rdata);
               if (widx_q == WIDX_W'(DW_COUNT)) begin
                  cnt_q <= mem_rdata[CNT_W-1:0];
                  ofs_q <= mem_rdata[DW-1 -: OFS_W];
               end
               if (widx_q == WIDX_W'(DW_RTYPE)) auto_q <= (mem_rdata == AUTO_RTYPE);
               if (widx_q == WIDX_W'(DESC_WORDS - 1)) state_q <= ST_WAIT;
               else widx_q <= widx_q + WIDX_W'(1);
            end
            ST_WAIT: if (en_q) state_q <= ST_CHECK;
            ST_CHECK: begin
               if (!code_ok || misaligned) begin
                  ar_q    <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (cnt_q == '0) begin
                  state_q <= ST_NEXT;
               end else begin
                  state_q <= ST_REQ;
               end
            end
            ST_REQ: if (auto_q || per_req) begin
               beat_q  <= beats_m1;
               state_q <= ST_RD;
            end
            ST_RD: if (mem_ready) begin
               data_q  <= mem_rdata;
               state_q <= ST_WR;
            end
            ST_WR: if (mem_ready) begin
               if (sai_q) src_q <= src_q + AW'(beat_bytes);
               if (dai_q) tgt_q <= tgt_q + AW'(beat_bytes);
               if (beat_q == 8'd0) begin
                  cnt_q   <= cnt_q - CNT_W'(1);
                  state_q <= (cnt_q == CNT_W'(1)) ? ST_NEXT : ST_REQ;
               end else begin
                  beat_q  <= beat_q - 8'd1;
                  state_q <= ST_RD;
               end
            end
            ST_NEXT: begin
               if (link_q) begin
                  cur_q   <= link_addr;
                  widx_q  <= '0;
                  state_q <= ST_FETCH;
               end else begin
                  tt_q    <= 1'b1;
                  ie_q    <= cmd_ie_q;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
         if (ctrl_wr) begin
            en_q   <= reg_wdata[CB_EN];
            d8_q   <= reg_wdata[CB_D8];
            halt_q <= (halt_q && reg_wdata[CB_HALT]) ||
                      (busy && !reg_wdata[CB_EN] && (|reg_wdata));
            tt_q   <= tt_q && reg_wdata[CB_TERM];
            ar_q   <= ar_q && reg_wdata[CB_ADDR_ERR];
            if (busy && !reg_wdata[CB_EN]) state_q <= ST_IDLE;
         end
      end
   end

endmodule

// File: rtl/dlc_dma_checker.sv
module dlc_dma_checker
   import dlc_dma_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input logic             clk,
   input logic             rst,
   input dlc_state_e       state,
   input logic             mem_req,
   input logic             mem_we,
   input logic             irq,
   input logic             tt,
   input logic             ar,
   input logic             halt,
   input logic [CNT_W-1:0] cnt,
   input logic             cnt_load,
   input logic             reg_we,
   input logic [1:0]       reg_addr
);

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
      (state == ST_IDLE) |-> !mem_req)
      else $error("idle channel accessed memory");

   p_write_after_read_r4: assert property (@(posedge clk) disable iff (rst)
      (mem_req && mem_we) |-> $past(mem_req))
      else $error("write beat without a preceding access");

   p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
      (!$past(cnt_load) && (cnt != $past(cnt))) |-> (cnt == $past(cnt) - CNT_W'(1)))
      else $error("live count moved by other than one unit");

   p_irq_has_term_r9: assert property (@(posedge clk) disable iff (rst)
      irq |-> tt)
      else $error("interrupt without termination flag");

   p_irq_sw_clear_r9: assert property (@(posedge clk) disable iff (rst)
      $fell(irq) |-> $past(reg_we && reg_addr == RA_CTRL))
      else $error("interrupt dropped without a status write");

   p_err_no_write_r11: assert property (@(posedge clk) disable iff (rst)
      ar |-> !(mem_req && mem_we))
      else $error("memory written while address error is flagged");

   p_halt_quiet_r12: assert property (@(posedge clk) disable iff (rst)
      halt |-> !mem_req)
      else $error("memory accessed while halted");

endmodule

bind dlc_dma_channel dlc_dma_checker #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .state    (state_q),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .irq      (irq),
   .tt       (tt_q),
   .ar       (ar_q),
   .halt     (halt_q),
   .cnt      (cnt_q),
   .cnt_load (cnt_load),
   .reg_we   (reg_we),
   .reg_addr (reg_addr)
);

// File: tb/tb_dlc_dma_channel.sv
`timescale 1ns/1ps
module tb_dlc_dma_channel;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        doorbell = 1'b0;
   logic        per_req = 1'b0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [3:0]  mem_be;
   logic        mem_ready = 1'b1;
   logic        irq;

   always #2.5 clk = ~clk;

   dlc_dma_channel dut (
      .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .doorbell(doorbell),
      .per_req(per_req), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready), .irq(irq)
   );

   // memory model: 1 KiB, combinational read, write at falling edge
   logic [31:0] mem [256];
   logic [31:0] exp_m [256];
   assign mem_rdata = mem[mem_addr[9:2]];
   always @(negedge clk) begin
      if (mem_req && mem_we)
         for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] = mem_wdata[8*b +: 8];
   end

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s actual %h expected %h", req, act, expv);
      end
   endtask

   task automatic chk_mem(input string req);
      int bad = 0;
      for (int i = 0; i < 256; i++)
         if (mem[i] !== exp_m[i]) begin
            if (bad == 0) $display("  first mismatching word %0d: %h vs %h", i, mem[i], exp_m[i]);
            bad++;
         end
      chk(req, bad, 0);
   endtask

   function automatic int unit_of(input int code);
      case (code)
         0: return 4;  1: return 1;  2: return 2;  3: return 16;
         4: return 32; 5: return 64; 6: return 128;
         default: return 4;
      endcase
   endfunction

   function automatic logic [31:0] mk_cmd(input int code, input bit sai, input bit dai,
                                          input bit link, input bit ie);
      return (32'(sai) << 23) | (32'(dai) << 22) | (32'(code) << 8) |
             (32'(ie) << 1) | 32'(link);
   endfunction

   // reference byte copy, applied to the expected image
   task automatic model_copy(input int code, input int n, input int src, input int tgt,
                             input bit sai, input bit dai);
      int u = unit_of(code);
      int b = (u < 4) ? u : 4;
      for (int k = 0; k < u * n; k++) begin
         int sa = sai ? src + k : src + (k % b);
         int ta = dai ? tgt + k : tgt + (k % b);
         exp_m[ta >> 2][8*(ta % 4) +: 8] = exp_m[sa >> 2][8*(sa % 4) +: 8];
      end
   endtask

   task automatic wdesc(input int at, input logic [31:0] cmd, input logic [31:0] src,
                        input logic [31:0] tgt, input logic [23:0] n,
                        input logic [7:0] ofs, input logic [31:0] rt);
      logic [31:0] w [8];
      w = '{cmd, src, tgt, {ofs, n}, 32'h0, rt, 32'h0, 32'h0};
      for (int i = 0; i < 8; i++) begin
         mem[(at >> 2) + i]   = w[i];
         exp_m[(at >> 2) + i] = w[i];
      end
   endtask

   task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic ring_bell();
      @(negedge clk);
      doorbell = 1'b1;
      @(negedge clk);
      doorbell = 1'b0;
   endtask

   task automatic wait_irq(input int limit, output bit seen);
      seen = 0;
      for (int i = 0; i < limit && !seen; i++) begin
         @(negedge clk);
         if (irq) seen = 1;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   typedef struct packed {
      logic [2:0]  code;
      logic [7:0]  n;
      logic [11:0] src;
      logic [11:0] tgt;
      logic        sai;
      logic        dai;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{3'd0, 8'd4, 12'h100, 12'h200, 1'b1, 1'b1},
      '{3'd1, 8'd6, 12'h105, 12'h212, 1'b1, 1'b1},
      '{3'd2, 8'd3, 12'h10A, 12'h222, 1'b1, 1'b1},
      '{3'd3, 8'd2, 12'h140, 12'h240, 1'b1, 1'b1},
      '{3'd0, 8'd3, 12'h180, 12'h280, 1'b0, 1'b1},
      '{3'd4, 8'd1, 12'h1A0, 12'h2C0, 1'b1, 1'b0}
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      logic [31:0] rd;
      bit seen;
      for (int i = 0; i < 256; i++) begin
         mem[i]   = (32'h9E3779B9 * 32'(i + 1)) ^ 32'(i);
         exp_m[i] = mem[i];
      end
      idle(5);
      rst = 1'b0;

      // R1: reset state
      reg_rd(2'd0, rd); chk("R1 descriptor address after reset", rd, 0);
      reg_rd(2'd1, rd); chk("R1 control/status after reset", rd, 0);
      reg_rd(2'd2, rd); chk("R1 live count after reset", rd, 0);
      chk("R1 irq after reset", irq, 0);
      chk("R1 no memory request after reset", mem_req, 0);

      // R4 R5 R9: single auto-request descriptors from the vector table
      for (int v = 0; v < 6; v++) begin
         vec_t t = VECS[v];
         wdesc(0, mk_cmd(t.code, t.sai, t.dai, 0, 1), 32'(t.src), 32'(t.tgt),
               24'(t.n), 8'd0, 32'd8);
         model_copy(t.code, t.n, t.src, t.tgt, t.sai, t.dai);
         reg_wr(2'd0, 32'h0);
         reg_wr(2'd1, 32'h4000_0001);
         ring_bell();
         wait_irq(3000, seen);
         chk("R9 irq raised on unlinked end", seen, 1);
         chk_mem("R4 R5 target image after descriptor");
         reg_rd(2'd1, rd); chk("R9 terminated flag set", rd, 32'h4000_0009);
         reg_rd(2'd2, rd); chk("R6 live count drained", rd, 0);
         reg_wr(2'd1, 32'h0);
         chk("R12 zero write drops irq", irq, 0);
      end

      // R7 R10 R6: linked pair, second waits for peripheral requests
      wdesc(0,  mk_cmd(0, 1, 1, 1, 1), 32'h300, 32'h340, 24'd2, 8'd2, 32'd8);
      wdesc(32, mk_cmd(0, 1, 1, 0, 1), 32'h310, 32'h360, 24'd3, 8'd0, 32'd4);
      model_copy(0, 2, 'h300, 'h340, 1, 1);
      reg_wr(2'd0, 32'h0);
      reg_wr(2'd1, 32'h4000_0001);
      ring_bell();
      idle(100);
      chk("R10 no irq after linked descriptor", irq, 0);
      reg_rd(2'd1, rd); chk("R10 no terminated flag after linked descriptor", rd, 32'h4000_0001);
      chk_mem("R7 first descriptor done before link");
      reg_rd(2'd2, rd); chk("R6 R7 count of linked descriptor held without request", rd, 3);
      per_req = 1'b1;
      model_copy(0, 3, 'h310, 'h360, 1, 1);
      wait_irq(500, seen);
      chk("R6 irq after requests arrive", seen, 1);
      chk_mem("R7 R6 chained image");
      per_req = 1'b0;
      reg_wr(2'd1, 32'h0);

      // R8 R12: ring closed by offset 0, stopped by halt
      wdesc(128, mk_cmd(0, 1, 1, 1, 1), 32'h380, 32'h3C0, 24'd2, 8'd2, 32'd8);
      wdesc(160, mk_cmd(0, 1, 1, 1, 1), 32'h390, 32'h380, 24'd2, 8'd0, 32'd8);
      model_copy(0, 2, 'h380, 'h3C0, 1, 1);
      model_copy(0, 2, 'h390, 'h380, 1, 1);
      model_copy(0, 2, 'h380, 'h3C0, 1, 1);
      reg_wr(2'd0, 32'h80);
      reg_wr(2'd1, 32'h4000_0001);
      ring_bell();
      idle(300);
      chk("R8 ring raises no irq", irq, 0);
      reg_wr(2'd1, 32'h4000_0000);
      reg_rd(2'd1, rd); chk("R12 halt flag after stop", rd, 32'h4000_0004);
      chk_mem("R8 ring returned to base descriptor");
      reg_wr(2'd1, 32'h0);
      reg_rd(2'd1, rd); chk("R12 zero write clears halt", rd, 0);

      // R11: misaligned source, then unit code 7
      wdesc(0, mk_cmd(3, 1, 1, 0, 1), 32'h104, 32'h200, 24'd1, 8'd0, 32'd8);
      reg_wr(2'd0, 32'h0);
      reg_wr(2'd1, 32'h4000_0001);
      ring_bell();
      idle(40);
      reg_rd(2'd1, rd); chk("R11 address error on misaligned unit", rd, 32'h4000_0011);
      chk("R11 no irq on address error", irq, 0);
      chk_mem("R11 memory untouched on misalignment");
      reg_wr(2'd1, 32'h0);
      wdesc(0, mk_cmd(7, 1, 1, 0, 1), 32'h100, 32'h200, 24'd1, 8'd0, 32'd8);
      reg_wr(2'd0, 32'h0);
      reg_wr(2'd1, 32'h4000_0001);
      ring_bell();
      idle(40);
      reg_rd(2'd1, rd); chk("R11 address error on unit code 7", rd, 32'h4000_0011);
      chk_mem("R11 memory untouched on bad unit code");
      reg_wr(2'd1, 32'h0);
      reg_rd(2'd1, rd); chk("R12 zero write clears address error", rd, 0);

      // R2: doorbell without a fresh descriptor address does nothing
      wdesc(0, mk_cmd(0, 1, 1, 0, 1), 32'h100, 32'h3E0, 24'd4, 8'd0, 32'd8);
      reg_wr(2'd1, 32'h4000_0001);
      ring_bell();
      idle(60);
      chk_mem("R2 doorbell alone moves nothing");
      reg_rd(2'd1, rd); chk("R2 doorbell alone sets no status", rd, 32'h4000_0001);

      // R3: fetched descriptor waits for enable
      reg_wr(2'd1, 32'h4000_0000);
      reg_wr(2'd0, 32'h0);
      ring_bell();
      idle(40);
      reg_rd(2'd2, rd); chk("R3 loaded count visible while disabled", rd, 4);
      chk_mem("R3 nothing moved while disabled");
      model_copy(0, 4, 'h100, 'h3E0, 1, 1);
      reg_wr(2'd1, 32'h4000_0001);
      wait_irq(500, seen);
      chk("R3 enable starts held descriptor", seen, 1);
      chk_mem("R3 R2 image after enable");
      reg_wr(2'd1, 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule